// File: doc/BRIEF.md
# CAN Transmit Buffer Request Controller

This block keeps the control and status state of eight message buffers in a CAN controller. Each buffer works as either a transmit or a receive buffer. For every buffer, software sets a send request, a two-bit priority and an auto-reply option through a small register port. The port has four 16-bit words, and each word serves one pair of buffers. The block picks the pending transmit buffer with the highest priority and offers its index to a CAN protocol engine. The engine answers with an outcome event for a buffer: sent, lost arbitration, bus error or aborted. The block turns that event into the buffer's request bit and its sticky status flags.

The request bit is managed jointly by software and hardware. Software sets it to queue a message, and setting it clears the old status flags. Hardware clears it when the message completes. A received remote frame can set it again when the buffer allows automatic replies. If software writes 0 to a request that is still set, the request is not dropped. Instead it becomes an abort request on the `abort_req` output, and that lasts until the engine reports the buffer as aborted or sent. A buffer with an abort request outstanding is not offered again.

Events and remote frames act on the request value held before the clock edge. In one cycle, a register write is applied first and an engine event applied last, so the event decides the final result.

Top module: `can_txq_ctrl`

## Requirements
- R1: After a synchronous reset, every field of every buffer is 0, no buffer is offered and no abort request is raised.
- R2: Word w holds buffer 2w in bits 7..0 and buffer 2w+1 in bits 15..8. Each byte is laid out as: bit 7 transmit enable (1 = transmit, 0 = receive), bit 6 aborted, bit 5 lost arbitration, bit 4 bus error, bit 3 send request, bit 2 auto-reply enable, bits 1..0 priority. A write changes only the bytes whose enable in `reg_wr_be` is set (bit 0 for the low byte, bit 1 for the high byte), and `reg_rdata` always shows the word selected by `reg_addr`.
- R3: Writes to the aborted, lost-arbitration and bus-error bits are ignored.
- R4: A write that sets a send request that was 0 clears that buffer's aborted, lost-arbitration and bus-error flags.
- R5: Writing 0 to a send request that is 1 leaves the request at 1 and raises `abort_req` for that buffer. That buffer is no longer offered.
- R6: When `eng_busy` is 0, `offer_valid` is 1 if any buffer has transmit enable and send request set and no abort outstanding. `offer_idx` then names the eligible buffer with the highest priority (3 highest, 0 lowest), and the lowest index wins a tie. `offer_valid` is 0 while `eng_busy` is 1.
- R7: Event code 0 (sent) clears the buffer's send request and its abort request, and leaves the flags unchanged.
- R8: Event code 1 (lost arbitration) sets the lost-arbitration flag, and event code 2 (bus error) sets the bus-error flag. In both cases the send request stays at 1, so the buffer retries.
- R9: Event code 3 (aborted) sets the aborted flag and clears the send request and the abort request.
- R10: An event aimed at a buffer whose send request is 0 has no effect.
- R11: A remote frame for a buffer with auto-reply enable set and send request 0 sets the request and clears the three flags. With auto-reply enable at 0, the frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_be | input | 2 | Byte enables: bit 0 for the even buffer, bit 1 for the odd buffer |
| reg_addr | input | 2 | Word select for both read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word |
| eng_busy | input | 1 | Protocol engine cannot take a new buffer |
| offer_valid | output | 1 | A buffer is offered to the engine |
| offer_idx | output | 3 | Index of the offered buffer |
| abort_req | output | 8 | Abort request outstanding, one bit per buffer |
| evt_valid | input | 1 | Engine outcome event strobe |
| evt_idx | input | 3 | Buffer that the event refers to |
| evt_kind | input | 2 | 0 sent, 1 lost arbitration, 2 bus error, 3 aborted |
| rtr_valid | input | 1 | Remote frame matched a buffer |
| rtr_idx | input | 3 | Buffer matched by the remote frame |

## Verification
The hardest case to reach is a buffer that has an abort request outstanding when the engine returns an event for it. Software has to clear the request while the request is still set, and the engine's answer has to arrive before anything else changes the buffer. The directed part of the bench builds this case step by step. The random part aims three quarters of the events at the buffer currently offered, and issues frequent register writes with random request bits. Together these often produce request-clear writes on live buffers, sometimes in the same cycle as an event.

// File: rtl/can_txq_pkg.sv
package can_txq_pkg;

    localparam int PRIO_W = 2;
    localparam int WORD_W = 16;
    localparam int SLOT_W = 8;

    typedef struct packed {
        logic              tx_en;
        logic              aborted;
        logic              lost_arb;
        logic              bus_err;
        logic              send_req;
        logic              auto_rtr;
        logic [PRIO_W-1:0] prio;
    } slot_ctl_t;

    typedef enum logic [1:0] {
        EV_SENT    = 2'd0,
        EV_LOST    = 2'd1,
        EV_BUSERR  = 2'd2,
        EV_ABORTED = 2'd3
    } txev_e;

    function automatic slot_ctl_t clear_flags(input slot_ctl_t s);
        slot_ctl_t r;
        r          = s;
        r.aborted  = 1'b0;
        r.lost_arb = 1'b0;
        r.bus_err  = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/txq_slot.sv
module txq_slot
    import can_txq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  slot_ctl_t wr_val,
    input  logic      rtr_hit,
    input  logic      ev_hit,
    input  txev_e     ev_kind,
    output slot_ctl_t ctl_q,
    output logic      abort_pend_q
);

    slot_ctl_t ctl_d;
    logic      pend_d;

    always_comb begin
        ctl_d  = ctl_q;
        pend_d = abort_pend_q;

        // software write: configuration fields, request set / abort request
        if (wr_en) begin
            ctl_d.tx_en    = wr_val.tx_en;
            ctl_d.auto_rtr = wr_val.auto_rtr;
            ctl_d.prio     = wr_val.prio;
            if (wr_val.send_req && !ctl_q.send_req) begin
                ctl_d          = clear_flags(ctl_d);
                ctl_d.send_req = 1'b1;
                pend_d         = 1'b0;
            end else if (!wr_val.send_req && ctl_q.send_req) begin
                pend_d = 1'b1;
            end
        end

        // remote frame re-arms an idle buffer
        if (rtr_hit && ctl_q.auto_rtr && !ctl_q.send_req) begin
            ctl_d          = clear_flags(ctl_d);
            ctl_d.send_req = 1'b1;
        end

        // engine outcome, only for a buffer that was requested
        if (ev_hit && ctl_q.send_req) begin
            unique case (ev_kind)
                EV_SENT: begin
                    ctl_d.send_req = 1'b0;
                    pend_d         = 1'b0;
                end
                EV_LOST:   ctl_d.lost_arb = 1'b1;
                EV_BUSERR: ctl_d.bus_err  = 1'b1;
                EV_ABORTED: begin
                    ctl_d.aborted  = 1'b1;
                    ctl_d.send_req = 1'b0;
                    pend_d         = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q        <= '0;
            abort_pend_q <= 1'b0;
        end else begin
            ctl_q        <= ctl_d;
            abort_pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/txq_pick.sv
module txq_pick #(
    parameter int NB = 8,
    parameter int IW = 3,
    parameter int PW = 2
) (
    input  logic [NB-1:0]         elig,
    input  logic [NB-1:0][PW-1:0] prio,
    output logic                  any,
    output logic [IW-1:0]         idx
);

    logic [PW-1:0] best_p;

    always_comb begin
        any    = 1'b0;
        idx    = '0;
        best_p = '0;
        // strict compare keeps the lowest index on equal priority
        for (int i = 0; i < NB; i++) begin
            if (elig[i] && (!any || prio[i] > best_p)) begin
                any    = 1'b1;
                best_p = prio[i];
                idx    = IW'(i);
            end
        end
    end

endmodule

// File: rtl/txq_rdmux.sv
module txq_rdmux
    import can_txq_pkg::*;
#(
    parameter int NB = 8,
    parameter int AW = 2
) (
    input  slot_ctl_t [NB-1:0] slots,
    input  logic [AW-1:0]      addr,
    output logic [WORD_W-1:0]  rdata
);

    localparam int NW = NB / 2;

    logic [NW-1:0][WORD_W-1:0] words;

    for (genvar w = 0; w < NW; w++) begin : g_word
        assign words[w] = {slots[2*w+1], slots[2*w]};
    end

    assign rdata = words[addr];

endmodule

// File: rtl/can_txq_ctrl.sv
module can_txq_ctrl
    import can_txq_pkg::*;
#(
    parameter  int NUM_BUF = 8,
    localparam int IDX_W   = $clog2(NUM_BUF),
    localparam int NUM_WRD = NUM_BUF / 2,
    localparam int ADDR_W  = (NUM_WRD > 1) ? $clog2(NUM_WRD) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_wr_be,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic               eng_busy,
    output logic               offer_valid,
    output logic [IDX_W-1:0]   offer_idx,
    output logic [NUM_BUF-1:0] abort_req,
    input  logic               evt_valid,
    input  logic [IDX_W-1:0]   evt_idx,
    input  logic [1:0]         evt_kind,
    input  logic               rtr_valid,
    input  logic [IDX_W-1:0]   rtr_idx
);

    slot_ctl_t [NUM_BUF-1:0]             slots_q;
    logic [NUM_BUF-1:0]                  pend_v;
    logic [NUM_BUF-1:0]                  ten_v, req_v, abt_v, larb_v, berr_v, elig_v;
    logic [NUM_BUF-1:0][PRIO_W-1:0]      prio_v;
    txev_e                               ev_kind_e;
    logic                                pick_any;

    assign ev_kind_e = txev_e'(evt_kind);

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
        logic      wr_hit;
        slot_ctl_t wr_byte;

        assign wr_hit  = reg_wr_en && (reg_addr == ADDR_W'(g / 2)) && reg_wr_be[g % 2];
        assign wr_byte = slot_ctl_t'(reg_wdata[(g % 2)*SLOT_W +: SLOT_W]);

        txq_slot u_slot (
            .clk          (clk),
            .rst          (rst),
            .wr_en        (wr_hit),
            .wr_val       (wr_byte),
            .rtr_hit      (rtr_valid && (rtr_idx == IDX_W'(g))),
            .ev_hit       (evt_valid && (evt_idx == IDX_W'(g))),
            .ev_kind      (ev_kind_e),
            .ctl_q        (slots_q[g]),
            .abort_pend_q (pend_v[g])
        );

        assign ten_v[g]  = slots_q[g].tx_en;
        assign req_v[g]  = slots_q[g].send_req;
        assign abt_v[g]  = slots_q[g].aborted;
        assign larb_v[g] = slots_q[g].lost_arb;
        assign berr_v[g] = slots_q[g].bus_err;
        assign prio_v[g] = slots_q[g].prio;
        assign elig_v[g] = slots_q[g].tx_en && slots_q[g].send_req && !pend_v[g];
    end

    txq_pick #(.NB(NUM_BUF), .IW(IDX_W), .PW(PRIO_W)) u_pick (
        .elig (elig_v),
        .prio (prio_v),
        .any  (pick_any),
        .idx  (offer_idx)
    );

    assign offer_valid = pick_any && !eng_busy;
    assign abort_req   = pend_v;

    txq_rdmux #(.NB(NUM_BUF), .AW(ADDR_W)) u_rdmux (
        .slots (slots_q),
        .addr  (reg_addr),
        .rdata (reg_rdata)
    );

endmodule

// File: rtl/can_txq_chk.sv
module can_txq_chk #(
    parameter int NB = 8,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          eng_busy,
    input logic          offer_valid,
    input logic [IW-1:0] offer_idx,
    input logic          evt_valid,
    input logic [IW-1:0] evt_idx,
    input logic [1:0]    evt_kind,
    input logic [NB-1:0] ten_v,
    input logic [NB-1:0] req_v,
    input logic [NB-1:0] abt_v,
    input logic [NB-1:0] larb_v,
    input logic [NB-1:0] berr_v,
    input logic [NB-1:0] pend_v
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (req_v == '0 && ten_v == '0 && abt_v == '0 && larb_v == '0
                 && berr_v == '0 && pend_v == '0 && !offer_valid));

    // R6
    offer_gate_chk: assert property (@(posedge clk) disable iff (rst)
        offer_valid |-> !eng_busy);

    // R6
    offer_elig_chk: assert property (@(posedge clk) disable iff (rst)
        offer_valid |-> (ten_v[offer_idx] && req_v[offer_idx] && !pend_v[offer_idx]));

    // R7
    sent_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_kind == 2'd0 && req_v[evt_idx])
        |=> (!req_v[$past(evt_idx)] && !pend_v[$past(evt_idx)]));

    // R8
    lost_retry_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_kind == 2'd1 && req_v[evt_idx])
        |=> (req_v[$past(evt_idx)] && larb_v[$past(evt_idx)]));

    // R8
    berr_retry_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_kind == 2'd2 && req_v[evt_idx])
        |=> (req_v[$past(evt_idx)] && berr_v[$past(evt_idx)]));

    // R9
    abort_done_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_kind == 2'd3 && req_v[evt_idx])
        |=> (!req_v[$past(evt_idx)] && abt_v[$past(evt_idx)] && !pend_v[$past(evt_idx)]));

    for (genvar i = 0; i < NB; i++) begin : g_rise
        // R4
        req_rise_flags_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(req_v[i]) |-> (!abt_v[i] && !larb_v[i] && !berr_v[i]));
    end

endmodule

bind can_txq_ctrl can_txq_chk #(.NB(NUM_BUF), .IW(IDX_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .eng_busy    (eng_busy),
    .offer_valid (offer_valid),
    .offer_idx   (offer_idx),
    .evt_valid   (evt_valid),
    .evt_idx     (evt_idx),
    .evt_kind    (evt_kind),
    .ten_v       (ten_v),
    .req_v       (req_v),
    .abt_v       (abt_v),
    .larb_v      (larb_v),
    .berr_v      (berr_v),
    .pend_v      (pend_v)
);

// File: tb/can_txq_ctrl_test.sv
module can_txq_ctrl_test;

    localparam int NB = 8;

    logic        clk, rst;
    logic        reg_wr_en;
    logic [1:0]  reg_wr_be;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        eng_busy;
    logic        offer_valid;
    logic [2:0]  offer_idx;
    logic [7:0]  abort_req;
    logic        evt_valid;
    logic [2:0]  evt_idx;
    logic [1:0]  evt_kind;
    logic        rtr_valid;
    logic [2:0]  rtr_idx;

    can_txq_ctrl uut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_be(reg_wr_be), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_busy(eng_busy), .offer_valid(offer_valid), .offer_idx(offer_idx),
        .abort_req(abort_req),
        .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_kind(evt_kind),
        .rtr_valid(rtr_valid), .rtr_idx(rtr_idx)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model of the requirements
    logic [7:0] m_ten, m_abt, m_larb, m_berr, m_req, m_rtr, m_pend;
    logic [1:0] m_prio [NB];

    function automatic logic [7:0] exp_byte(input int i);
        return {m_ten[i], m_abt[i], m_larb[i], m_berr[i], m_req[i], m_rtr[i], m_prio[i]};
    endfunction

    function automatic logic [15:0] exp_word(input int a);
        return {exp_byte(2*a+1), exp_byte(2*a)};
    endfunction

    function automatic logic [3:0] exp_offer(input logic busy);
        logic       found = 1'b0;
        logic [1:0] bp = 2'd0;
        logic [2:0] bi = 3'd0;
        for (int i = 0; i < NB; i++) begin
            if (m_ten[i] && m_req[i] && !m_pend[i] && (!found || m_prio[i] > bp)) begin
                found = 1'b1; bp = m_prio[i]; bi = 3'(i);
            end
        end
        return {found && !busy, bi};
    endfunction

    task automatic model_reset();
        m_ten = '0; m_abt = '0; m_larb = '0; m_berr = '0;
        m_req = '0; m_rtr = '0; m_pend = '0;
        for (int i = 0; i < NB; i++) m_prio[i] = 2'd0;
    endtask

    task automatic model_step();
        logic [7:0] o_req, o_rtr;
        o_req = m_req; o_rtr = m_rtr;
        for (int i = 0; i < NB; i++) begin
            logic [7:0] b;
            b = (i % 2 == 1) ? reg_wdata[15:8] : reg_wdata[7:0];
            if (reg_wr_en && reg_addr == 2'(i / 2) && reg_wr_be[i % 2]) begin
                m_ten[i] = b[7]; m_rtr[i] = b[2]; m_prio[i] = b[1:0];
                if (b[3] && !o_req[i]) begin
                    m_req[i] = 1'b1; m_abt[i] = 1'b0; m_larb[i] = 1'b0;
                    m_berr[i] = 1'b0; m_pend[i] = 1'b0;
                end else if (!b[3] && o_req[i]) begin
                    m_pend[i] = 1'b1;
                end
            end
            if (rtr_valid && rtr_idx == 3'(i) && o_rtr[i] && !o_req[i]) begin
                m_req[i] = 1'b1; m_abt[i] = 1'b0; m_larb[i] = 1'b0; m_berr[i] = 1'b0;
            end
            if (evt_valid && evt_idx == 3'(i) && o_req[i]) begin
                case (evt_kind)
                    2'd0: begin m_req[i] = 1'b0; m_pend[i] = 1'b0; end
                    2'd1: m_larb[i] = 1'b1;
                    2'd2: m_berr[i] = 1'b1;
                    default: begin m_abt[i] = 1'b1; m_req[i] = 1'b0; m_pend[i] = 1'b0; end
                endcase
            end
        end
    endtask

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // called just after a falling edge with inputs set; checks, then clocks
    task automatic cycle(input string tag);
        logic [3:0] eo;
        #1;
        eo = exp_offer(eng_busy);
        check(tag, "rdata", reg_rdata, exp_word(int'(reg_addr)));
        check(tag, "offer_valid", 16'(offer_valid), 16'(eo[3]));
        if (eo[3]) check(tag, "offer_idx", 16'(offer_idx), 16'(eo[2:0]));
        check(tag, "abort_req", 16'(abort_req), 16'(m_pend));
        @(posedge clk);
        model_step();
        @(negedge clk);
        reg_wr_en = 1'b0; evt_valid = 1'b0; rtr_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d, input string tag);
        reg_wr_en = 1'b1; reg_addr = a; reg_wr_be = be; reg_wdata = d;
        cycle(tag);
    endtask

    task automatic ev(input logic [2:0] i, input logic [1:0] k, input string tag);
        evt_valid = 1'b1; evt_idx = i; evt_kind = k;
        cycle(tag);
    endtask

    task automatic rtr(input logic [2:0] i, input string tag);
        rtr_valid = 1'b1; rtr_idx = i;
        cycle(tag);
    endtask

    task automatic idle(input logic [1:0] a, input string tag);
        reg_addr = a;
        cycle(tag);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h0005_eed5);
        reg_wr_en = 0; reg_wr_be = 0; reg_addr = 0; reg_wdata = 0;
        eng_busy = 0; evt_valid = 0; evt_idx = 0; evt_kind = 0;
        rtr_valid = 0; rtr_idx = 0;
        rst = 1'b1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state of every word
        for (int a = 0; a < 4; a++) idle(2'(a), "R1");

        // R2 layout and byte pairing, R6 selection
        wr(2'd0, 2'b11, {8'b1000_1011, 8'b1000_1001}, "R2");
        idle(2'd0, "R2");
        idle(2'd0, "R6");
        wr(2'd2, 2'b11, {8'h8B, 8'h8B}, "R6");
        idle(2'd2, "R6");
        wr(2'd1, 2'b01, 16'h008A, "R2");
        idle(2'd1, "R2");
        eng_busy = 1'b1;
        idle(2'd0, "R6");
        eng_busy = 1'b0;

        // R8 lost arbitration keeps the request
        ev(3'd1, 2'd1, "R8");
        idle(2'd0, "R8");

        // R3 status bits not writable
        wr(2'd0, 2'b10, {8'b1111_1011, 8'h00}, "R3");
        idle(2'd0, "R3");

        // R7 completion
        ev(3'd1, 2'd0, "R7");
        idle(2'd0, "R7");

        // R4 setting the request wipes flags
        wr(2'd0, 2'b10, {8'h8B, 8'h00}, "R4");
        idle(2'd0, "R4");

        // R5 abort request, then R9 completed abort
        wr(2'd0, 2'b10, {8'h83, 8'h00}, "R5");
        idle(2'd0, "R5");
        idle(2'd0, "R6");
        ev(3'd1, 2'd3, "R9");
        idle(2'd0, "R9");

        // R10 events on idle buffers
        ev(3'd1, 2'd2, "R10");
        ev(3'd3, 2'd3, "R10");
        idle(2'd0, "R10");
        idle(2'd1, "R10");

        // R11 remote frames
        wr(2'd3, 2'b11, {8'h80, 8'h84}, "R11");
        rtr(3'd6, "R11");
        rtr(3'd7, "R11");
        idle(2'd3, "R11");

        // R8 bus error keeps the request
        ev(3'd4, 2'd2, "R8");
        idle(2'd2, "R8");

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            reg_addr = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) begin
                reg_wr_en = 1'b1;
                reg_wr_be = 2'($urandom_range(1, 3));
                reg_wdata = 16'($urandom);
            end
            eng_busy = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 2) == 0) begin
                evt_valid = 1'b1;
                evt_idx   = (offer_valid && $urandom_range(0, 3) != 0) ? offer_idx : 3'($urandom_range(0, 7));
                evt_kind  = 2'($urandom_range(0, 3));
            end
            if ($urandom_range(0, 7) == 0) begin
                rtr_valid = 1'b1;
                rtr_idx   = 3'($urandom_range(0, 7));
            end
            cycle((n % 2 == 0) ? "R6" : "R2");
        end

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule